// File: doc/BRIEF.md
# Address Translation Buffer with Hardware Table Walk

This block translates 32-bit virtual addresses into physical addresses for a memory management unit. It holds a small fully associative set of recent translations. Every stored virtual page number is compared with the incoming one in the same cycle. On a match, the block returns the frame number joined to the untouched 12-bit page offset one clock after the request is accepted.

When no entry matches, the block walks a single-level page table in memory by itself. It issues one read at the table base plus the virtual page number and installs the returned entry. The translation is then returned in the cycle after the read data comes back. Missing pages and accesses that break the page's read or write rights are reported as faults instead of translations. Writes mark the cached entry as modified.

A flush input invalidates every cached translation. If a walk is underway, the flush waits until that walk has finished.

Top module: `tlb_walker`

## Requirements
- R1: A successful translation returns resp_paddr = {frame number, req_vaddr[11:0]}. The frame comes from the matching cached entry or from the fetched table entry. A faulting response carries resp_paddr = 0 and resp_modified = 0.
- R2: A request accepted while req_ready is high is compared against all valid entries at once. On a match, resp_valid rises in the following cycle and no memory read is issued.
- R3: On a miss, mem_rd_en pulses for exactly one cycle, starting in the cycle after acceptance, with mem_rd_addr = ptbr + virtual page number. req_ready stays low until the response has been given. The response is registered in the cycle after mem_rd_valid.
- R4: A table entry word holds these fields: present in bit 0, modified in bit 1, read-allowed in bit 2, write-allowed in bit 3, and the frame number in bits 31:12.
- R5: A fetched entry whose present bit is 0 gives resp_page_fault = 1 and is not installed, so the next access to that page walks again.
- R6: A write to a page whose write-allowed bit is 0, or a read to a page whose read-allowed bit is 0, gives resp_perm_fault = 1. This holds for both hits and walks. The two fault outputs are never high together.
- R7: A permitted write sets the modified bit of its cached entry. resp_modified reports that entry's modified bit after the access.
- R8: A refill takes the lowest-numbered invalid entry. If there is none, it takes the entry at a rotating pointer. The pointer starts at 0, advances by one (wrapping) after each such replacement, and is not changed by a flush.
- R9: A flush invalidates every entry. req_ready is low in the cycle after the flush pulse. A walk in progress completes and installs its entry, and that entry is then cleared by the flush as well.
- R10: After reset all entries are invalid, req_ready is 1, and resp_valid and mem_rd_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached translations |
| ptbr | input | 32 | Word address of the page table base |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | 32 | Physical address, zero on a fault |
| resp_page_fault | output | 1 | Page not present |
| resp_perm_fault | output | 1 | Access type not allowed on the page |
| resp_modified | output | 1 | Modified bit of the entry after the access |
| mem_rd_en | output | 1 | Page table read strobe |
| mem_rd_addr | output | 32 | Page table read word address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Page table entry word |

## Verification
A corrupted valid bit or tag shows up in the very next request to that page. Either an unexpected mem_rd_en pulse appears, or an expected one is missing. A wrong frame or permission field appears as a bad resp_paddr or fault flag on the first later hit to that entry. A faulty rotating pointer or free-entry search is only visible later, as a missing or extra walk once the buffer has filled and the evicted page is touched again. For that reason the stimulus reuses a page pool larger than the buffer, and every walk is checked against a reference model of the replacement order.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_MOD     = 1;
  localparam int BIT_RD      = 2;
  localparam int BIT_WR      = 3;

  typedef enum logic {WK_IDLE, WK_WAIT} wk_state_t;

  typedef struct packed {
    logic present;
    logic modified;
    logic rd_ok;
    logic wr_ok;
  } pte_flags_t;

  function automatic pte_flags_t flags_of(input logic [3:0] low);
    pte_flags_t f;
    f.present  = low[BIT_PRESENT];
    f.modified = low[BIT_MOD];
    f.rd_ok    = low[BIT_RD];
    f.wr_ok    = low[BIT_WR];
    return f;
  endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_all,
  input  logic [VPN_W-1:0] lookup_vpn,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [PFN_W-1:0] hit_pfn,
  output logic             hit_m,
  output logic             hit_r,
  output logic             hit_w,
  output logic [ENTRIES-1:0] valid_vec,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_m,
  input  logic             fill_r,
  input  logic             fill_w,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx
);

  logic [ENTRIES-1:0] ent_v;
  logic [ENTRIES-1:0] ent_m;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn [ENTRIES];
  logic [ENTRIES-1:0] ent_r;
  logic [ENTRIES-1:0] ent_w;
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_v[g] && (ent_vpn[g] == lookup_vpn);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit       = |match;
  assign hit_pfn   = ent_pfn[hit_idx];
  assign hit_m     = ent_m[hit_idx];
  assign hit_r     = ent_r[hit_idx];
  assign hit_w     = ent_w[hit_idx];
  assign valid_vec = ent_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v <= '0;
      ent_m <= '0;
    end else if (clear_all) begin
      ent_v <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_en && fill_idx == IDX_W'(i)) begin
          ent_v[i] <= 1'b1;
          ent_m[i] <= fill_m;
        end else if (mark_en && mark_idx == IDX_W'(i)) begin
          ent_m[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_en && fill_idx == IDX_W'(i)) begin
        ent_vpn[i] <= fill_vpn;
        ent_pfn[i] <= fill_pfn;
        ent_r[i]   <= fill_r;
        ent_w[i]   <= fill_w;
      end
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               take,
  output logic [IDX_W-1:0]   victim_idx
);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_free   = ~&valid_vec;
  assign victim_idx = any_free ? free_idx : rr_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (take && !any_free) begin
      rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/tlb_walker.sv
module tlb_walker #(
  parameter int VA_W     = 32,
  parameter int OFF_W    = 12,
  parameter int PFN_W    = 20,
  parameter int ENTRIES  = 16,
  parameter int MEM_AW   = 32,
  parameter int PTE_BITS = 32,
  localparam int VPN_W   = VA_W - OFF_W,
  localparam int PA_W    = PFN_W + OFF_W,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic [MEM_AW-1:0]   ptbr,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic                req_write,
  output logic                resp_valid,
  output logic [PA_W-1:0]     resp_paddr,
  output logic                resp_page_fault,
  output logic                resp_perm_fault,
  output logic                resp_modified,
  output logic                mem_rd_en,
  output logic [MEM_AW-1:0]   mem_rd_addr,
  input  logic                mem_rd_valid,
  input  logic [PTE_BITS-1:0] mem_rd_data
);
  import tlb_pkg::*;

  wk_state_t        state;
  logic             flush_pend;
  logic [VPN_W-1:0] pend_vpn;
  logic [OFF_W-1:0] pend_off;
  logic             pend_wr;

  logic [VPN_W-1:0] req_vpn;
  logic [OFF_W-1:0] req_off;
  logic             accept;

  logic             hit, hit_m, hit_r, hit_w;
  logic [IDX_W-1:0] hit_idx;
  logic [PFN_W-1:0] hit_pfn;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0] victim_idx;

  pte_flags_t       pte_fl;
  logic [PFN_W-1:0] pte_pfn;
  logic             walk_done, walk_perm, fill_en, fill_m;
  logic             hit_perm, mark_en, clear_all;

  assign req_vpn   = req_vaddr[VA_W-1:OFF_W];
  assign req_off   = req_vaddr[OFF_W-1:0];
  assign req_ready = (state == WK_IDLE) && !flush_pend;
  assign accept    = req_valid && req_ready;

  assign pte_fl    = flags_of(mem_rd_data[3:0]);
  assign pte_pfn   = mem_rd_data[PTE_BITS-1 -: PFN_W];
  assign walk_done = (state == WK_WAIT) && mem_rd_valid;
  assign walk_perm = pend_wr ? !pte_fl.wr_ok : !pte_fl.rd_ok;
  assign fill_en   = walk_done && pte_fl.present;
  assign fill_m    = pte_fl.modified | (pend_wr & pte_fl.wr_ok);

  assign hit_perm  = req_write ? !hit_w : !hit_r;
  assign mark_en   = accept && hit && req_write && hit_w;
  assign clear_all = (state == WK_IDLE) && flush_pend;

  tlb_cam #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) u_cam (
    .clk(clk), .rst(rst), .clear_all(clear_all),
    .lookup_vpn(req_vpn),
    .hit(hit), .hit_idx(hit_idx), .hit_pfn(hit_pfn),
    .hit_m(hit_m), .hit_r(hit_r), .hit_w(hit_w),
    .valid_vec(valid_vec),
    .fill_en(fill_en), .fill_idx(victim_idx), .fill_vpn(pend_vpn),
    .fill_pfn(pte_pfn), .fill_m(fill_m),
    .fill_r(pte_fl.rd_ok), .fill_w(pte_fl.wr_ok),
    .mark_en(mark_en), .mark_idx(hit_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .valid_vec(valid_vec),
    .take(fill_en), .victim_idx(victim_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= WK_IDLE;
      flush_pend      <= 1'b0;
      pend_vpn        <= '0;
      pend_off        <= '0;
      pend_wr         <= 1'b0;
      resp_valid      <= 1'b0;
      resp_paddr      <= '0;
      resp_page_fault <= 1'b0;
      resp_perm_fault <= 1'b0;
      resp_modified   <= 1'b0;
      mem_rd_en       <= 1'b0;
      mem_rd_addr     <= '0;
    end else begin
      resp_valid <= 1'b0;
      mem_rd_en  <= 1'b0;
      if (clear_all) flush_pend <= 1'b0;
      if (flush)     flush_pend <= 1'b1;
      case (state)
        WK_IDLE: begin
          if (accept) begin
            if (hit) begin
              resp_valid      <= 1'b1;
              resp_page_fault <= 1'b0;
              resp_perm_fault <= hit_perm;
              resp_paddr      <= hit_perm ? '0 : {hit_pfn, req_off};
              resp_modified   <= hit_perm ? 1'b0 : (hit_m | req_write);
            end else begin
              pend_vpn    <= req_vpn;
              pend_off    <= req_off;
              pend_wr     <= req_write;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= ptbr + MEM_AW'(req_vpn);
              state       <= WK_WAIT;
            end
          end
        end
        WK_WAIT: begin
          if (walk_done) begin
            resp_valid      <= 1'b1;
            resp_page_fault <= !pte_fl.present;
            resp_perm_fault <= pte_fl.present && walk_perm;
            if (pte_fl.present && !walk_perm) begin
              resp_paddr    <= {pte_pfn, pend_off};
              resp_modified <= fill_m;
            end else begin
              resp_paddr    <= '0;
              resp_modified <= 1'b0;
            end
            state <= WK_IDLE;
          end
        end
        default: state <= WK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tlb_walker_chk.sv
module tlb_walker_chk #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 32,
  parameter int MEM_AW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            resp_valid,
  input logic [PA_W-1:0] resp_paddr,
  input logic            resp_page_fault,
  input logic            resp_perm_fault,
  input logic            mem_rd_en
);

  a_r3_single_read_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready);

  a_r2_hit_or_walk: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && req_ready) |-> (resp_valid ^ mem_rd_en));

  a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_page_fault && !resp_perm_fault && $past(req_valid && req_ready))
      |-> resp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

  a_r6_faults_exclusive: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !(resp_page_fault && resp_perm_fault));

  a_r6_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && (resp_page_fault || resp_perm_fault)) |-> resp_paddr == '0);

  a_r9_flush_blocks_ready: assert property (@(posedge clk) disable iff (rst)
    flush |=> !req_ready);

endmodule

bind tlb_walker tlb_walker_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .MEM_AW(MEM_AW)
) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
  .req_ready(req_ready), .req_vaddr(req_vaddr), .resp_valid(resp_valid),
  .resp_paddr(resp_paddr), .resp_page_fault(resp_page_fault),
  .resp_perm_fault(resp_perm_fault), .mem_rd_en(mem_rd_en)
);

// File: tb/tb_tlb_walker.sv
`timescale 1ns/1ps
module tb_tlb_walker;

  localparam logic [31:0] PTBR = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        resp_valid;
  logic [31:0] resp_paddr;
  logic        resp_page_fault, resp_perm_fault, resp_modified;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic        m_v   [16];
  logic [19:0] m_vpn [16];
  logic        m_m   [16];
  int          m_rr;

  always #2 clk = ~clk;

  tlb_walker dut (
    .clk(clk), .rst(rst), .flush(flush), .ptbr(PTBR),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_page_fault(resp_page_fault), .resp_perm_fault(resp_perm_fault),
    .resp_modified(resp_modified), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data)
  );

  // Page table word for a page (R4 layout: P bit0, M bit1, R bit2, W bit3, frame 31:12)
  function automatic logic [31:0] pte_of(input logic [19:0] vpn);
    logic [19:0] pfn;
    logic p, m, r, w;
    pfn = (vpn * 20'd37 + 20'd5) ^ 20'hA5A5;
    p = (vpn % 5) != 0;
    m = vpn[2];
    r = (vpn % 11) != 3;
    w = vpn[1];
    return {pfn, 8'h00, w, r, m, p};
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= mem_rd_en && !rst;
    mem_rd_data  <= pte_of(20'(mem_rd_addr - PTBR));
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_flush();
    for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
  endtask

  // Reference behaviour from R1, R5..R8
  task automatic model_access(input logic [19:0] vpn, input logic [11:0] off, input bit wr,
                              output logic [31:0] pa, output bit pf, output bit perm,
                              output bit md, output int walks);
    int idx;
    logic [31:0] pte;
    idx = -1;
    for (int i = 0; i < 16; i++) if (m_v[i] && m_vpn[i] == vpn) idx = i;
    pte = pte_of(vpn);
    pf = 1'b0; perm = wr ? !pte[3] : !pte[2];
    walks = (idx < 0) ? 1 : 0;
    if (idx < 0) begin
      if (!pte[0]) begin
        pf = 1'b1; perm = 1'b0;
      end else begin
        for (int i = 15; i >= 0; i--) if (!m_v[i]) idx = i;
        if (idx < 0) begin
          idx = m_rr;
          m_rr = (m_rr + 1) % 16;
        end
        m_v[idx] = 1'b1; m_vpn[idx] = vpn; m_m[idx] = pte[1];
      end
    end
    if (!pf && !perm && wr) m_m[idx] = 1'b1;
    md = (!pf && !perm) ? m_m[idx] : 1'b0;
    pa = (!pf && !perm) ? {pte[31:12], off} : 32'h0;
  endtask

  task automatic access(input logic [19:0] vpn, input logic [11:0] off, input bit wr,
                        input bit flush_mid, input string tag);
    logic [31:0] e_pa; bit e_pf, e_perm, e_md; int e_walks;
    int walks; int cyc; logic [31:0] seen_addr;
    model_access(vpn, off, wr, e_pa, e_pf, e_perm, e_md, e_walks);
    while (!req_ready) @(negedge clk);
    req_vaddr = {vpn, off}; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    walks = 0; cyc = 0; seen_addr = '0;
    while (!resp_valid && cyc < 40) begin
      if (mem_rd_en) begin walks++; seen_addr = mem_rd_addr; end
      flush = flush_mid && (cyc == 0);
      @(negedge clk);
      cyc++;
    end
    flush = 1'b0;
    check({tag, " R2/R3 resp_valid"}, 64'(resp_valid), 64'd1);
    check({tag, " R1 paddr"}, 64'(resp_paddr), 64'(e_pa));
    check({tag, " R5 page fault"}, 64'(resp_page_fault), 64'(e_pf));
    check({tag, " R6 perm fault"}, 64'(resp_perm_fault), 64'(e_perm));
    check({tag, " R7 modified"}, 64'(resp_modified), 64'(e_md));
    check({tag, " R8 walk count"}, 64'(walks), 64'(e_walks));
    if (walks == 1) check({tag, " R3 read addr"}, 64'(seen_addr), 64'(PTBR + 32'(vpn)));
    if (flush_mid) model_flush();
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check("R9 ready low after flush", 64'(req_ready), 64'd0);
    @(negedge clk);
    check("R9 ready back after flush", 64'(req_ready), 64'd1);
    model_flush();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin m_v[i] = 1'b0; m_vpn[i] = '0; m_m[i] = 1'b0; end
    m_rr = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 ready after reset", 64'(req_ready), 64'd1);
    check("R10 resp_valid after reset", 64'(resp_valid), 64'd0);
    check("R10 no read after reset", 64'(mem_rd_en), 64'd0);

    access(20'd1, 12'h123, 1'b0, 1'b0, "R3 first miss");
    access(20'd1, 12'hFFF, 1'b0, 1'b0, "R2 hit");
    access(20'd1, 12'h000, 1'b1, 1'b0, "R6 write to read-only");
    access(20'd5, 12'h010, 1'b0, 1'b0, "R5 absent page");
    access(20'd5, 12'h010, 1'b0, 1'b0, "R5 absent page again");
    access(20'd3, 12'h044, 1'b0, 1'b0, "R6 read not allowed");
    access(20'd2, 12'h777, 1'b1, 1'b0, "R7 write miss sets modified");
    access(20'd2, 12'h778, 1'b0, 1'b0, "R7 read sees modified");
    access(20'd6, 12'h001, 1'b0, 1'b0, "R4 preset modified");
    do_flush();
    access(20'd2, 12'h779, 1'b0, 1'b0, "R9 miss after flush");
    access(20'd7, 12'h222, 1'b0, 1'b1, "R9 flush during walk");
    access(20'd7, 12'h223, 1'b0, 1'b0, "R9 entry cleared after walk");
    for (int k = 0; k < 20; k++)
      access(20'h3A000 + 20'(k), 12'(k * 97), 1'b0, 1'b0, "R8 fill sweep");
    for (int k = 0; k < 700; k++) begin
      access(20'h3A000 + 20'($urandom % 40), 12'($urandom), 1'($urandom), 1'b0, "R1 random");
    end
    do_flush();
    for (int k = 0; k < 200; k++)
      access(20'($urandom % 24), 12'($urandom), 1'($urandom), 1'b0, "R6 random low pages");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule